// File: doc/BRIEF.md
# Dual-Modulus Feedback Counter

This block sits in the feedback path of a frequency synthesizer. It is clocked by the output of an external two-modulus prescaler, which divides the RF input by either P or P+1. The block steers that prescaler through a modulus-control line so that one output pulse is issued for every N = B·P + A RF cycles. B is the number of prescaler output cycles in one period. A is how many of those cycles use the larger modulus P+1.

A small state machine runs the period. It has three states. `ST_HOLD` is the idle state, used after reset and whenever the programmed values are unusable. `ST_SWALLOW` asks the prescaler for P+1. `ST_MAIN` asks for P. Two down-counters sit under the state machine. One counts the remaining swallow cycles and the other counts the remaining prescaler cycles of the period. The programmed A, B and prescaler mode are sampled only at a period boundary. The mode is also passed on to the prescaler as a registered selection, so a change in the middle of a period never shortens that period.

The state transitions are:
- HOLD→SWALLOW: the values are valid and A>0.
- HOLD→MAIN: the values are valid and A=0.
- HOLD→HOLD: the values are invalid.
- SWALLOW→SWALLOW: swallow cycles remain.
- SWALLOW→MAIN: the last swallow cycle ends before the terminal count.
- SWALLOW or MAIN at the terminal count: the counters reload and the machine enters SWALLOW or MAIN for the new values, or HOLD if those values are invalid.

Top module: `nmod_feedback_div`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `mod_ctl_o` and `div_pulse_o` are 0 and `psc_mode_o` is 0.
- R2: A period lasts B clocks. `mod_ctl_o` is 1 (meaning "divide by P+1") in the first A clocks of the period and 0 in the remaining B−A clocks.
- R3: `div_pulse_o` is 1 for exactly the last clock of each period, which is the clock in which the B count is at its terminal value. It is 0 in every other clock.
- R4: The number of RF cycles between the end of one pulse and the end of the next equals B·P + A, where P = 8 << mode. With P=32, A=63 and B=891 this is 28575.
- R5: `psc_mode_o` gives the mode captured at the start of the current period. The encoding is 0→8/9, 1→16/17, 2→32/33 and 3→64/65.
- R6: `cfg_invalid_o` is 1 exactly when the programmed B is less than A, or B is 0. It follows the inputs directly.
- R7: A change of A, B or mode during a period has no effect on the outputs until the next period boundary.
- R8: If the values are invalid at a boundary, `mod_ctl_o` and `div_pulse_o` stay 0. Counting resumes one clock after valid values appear.
- R9: When A equals B, `mod_ctl_o` is 1 for the whole period. When B is 1, a pulse is issued on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_psc | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_i | input | 6 | Programmed A (number of P+1 cycles) |
| main_i | input | 13 | Programmed B (prescaler cycles per period) |
| psc_mode_i | input | 2 | Programmed prescaler modulus pair |
| mod_ctl_o | output | 1 | 1 selects P+1, 0 selects P |
| div_pulse_o | output | 1 | One-clock pulse per period |
| psc_mode_o | output | 2 | Modulus pair currently applied to the prescaler |
| cfg_invalid_o | output | 1 | Programmed values are unusable (B<A or B=0) |

## Verification
The checker covers the rules that hold on every clock:
- the period counter steps down by one on each clock that is not the terminal clock;
- the swallow count stays non-zero and no larger than the period count whenever P+1 is requested;
- the applied mode stays constant inside a period;
- a boundary taken with invalid values leaves both outputs quiet on the next clock.

Other behaviour can only be shown by the bench scenarios, where a behavioural reference model is compared on every clock. This covers the exact clock positions of the modulus edge and the pulse, the RF-cycle total per period for several modes, the 28575 case, the corner cases A=B and B=1, and edits made in the middle of a period.

// File: rtl/nmod_pkg.sv
package nmod_pkg;

    // Phases of one feedback period
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } nmod_state_e;

endpackage

// File: rtl/nmod_cfg_check.sv
module nmod_cfg_check #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    output logic           invalid_o
);

    logic [B_W-1:0] swallow_ext;

    // Widen A to the width of B before comparing; the variant depends on the widths
    generate
        if (B_W > A_W) begin : g_pad
            assign swallow_ext = {{(B_W-A_W){1'b0}}, swallow_i};
        end else begin : g_same
            assign swallow_ext = swallow_i[B_W-1:0];
        end
    endgenerate

    always_comb begin
        invalid_o = (main_i < swallow_ext) || (main_i == '0);
    end

endmodule

// File: rtl/nmod_dcount.sv
module nmod_dcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    always_comb begin
        at_one = (cnt == ONE);
    end

endmodule

// File: rtl/nmod_feedback_div.sv
module nmod_feedback_div #(
    parameter int A_W    = 6,
    parameter int B_W    = 13,
    parameter int MODE_W = 2
) (
    input  logic              clk_psc,
    input  logic              rst_n,
    input  logic [A_W-1:0]    swallow_i,
    input  logic [B_W-1:0]    main_i,
    input  logic [MODE_W-1:0] psc_mode_i,
    output logic              mod_ctl_o,
    output logic              div_pulse_o,
    output logic [MODE_W-1:0] psc_mode_o,
    output logic              cfg_invalid_o
);
    import nmod_pkg::*;

    nmod_state_e       state_q;
    nmod_state_e       state_d;
    nmod_state_e       entry_state;

    logic              cfg_bad;
    logic              boundary;
    logic              load_cfg;
    logic              run_q;

    logic [A_W-1:0]    a_cnt;
    logic [B_W-1:0]    b_cnt;
    logic              a_one;
    logic              b_one;
    logic              a_dec;
    logic              b_dec;
    logic [MODE_W-1:0] mode_q;

    nmod_cfg_check #(
        .A_W (A_W),
        .B_W (B_W)
    ) u_cfg (
        .swallow_i (swallow_i),
        .main_i    (main_i),
        .invalid_o (cfg_bad)
    );

    // Swallow counter: remaining P+1 cycles in this period
    nmod_dcount #(
        .W (A_W)
    ) u_acnt (
        .clk      (clk_psc),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .load_val (swallow_i),
        .dec      (a_dec),
        .cnt      (a_cnt),
        .at_one   (a_one)
    );

    // Main counter: remaining prescaler cycles in this period
    nmod_dcount #(
        .W (B_W)
    ) u_bcnt (
        .clk      (clk_psc),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .load_val (main_i),
        .dec      (b_dec),
        .cnt      (b_cnt),
        .at_one   (b_one)
    );

    // A period ends at the terminal count or while idling
    always_comb begin
        run_q       = (state_q != ST_HOLD);
        boundary    = !run_q || b_one;
        load_cfg    = boundary && !cfg_bad;
        entry_state = cfg_bad ? ST_HOLD
                    : ((swallow_i == '0) ? ST_MAIN : ST_SWALLOW);
    end

    // State register
    always_ff @(posedge clk_psc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                state_d = entry_state;
            end
            ST_SWALLOW: begin
                if (b_one) begin
                    state_d = entry_state;
                end else if (a_one) begin
                    state_d = ST_MAIN;
                end else begin
                    state_d = ST_SWALLOW;
                end
            end
            ST_MAIN: begin
                if (b_one) begin
                    state_d = entry_state;
                end else begin
                    state_d = ST_MAIN;
                end
            end
            default: begin
                state_d = ST_HOLD;
            end
        endcase
    end

    // Counter stepping
    always_comb begin
        a_dec = (state_q == ST_SWALLOW) && !b_one;
        b_dec = run_q && !b_one;
    end

    // Mode applied to the prescaler, captured only at a boundary
    always_ff @(posedge clk_psc or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (load_cfg) begin
            mode_q <= psc_mode_i;
        end
    end

    // Outputs
    always_comb begin
        mod_ctl_o     = 1'b0;
        div_pulse_o   = 1'b0;
        psc_mode_o    = mode_q;
        cfg_invalid_o = cfg_bad;
        unique case (state_q)
            ST_HOLD: begin
                mod_ctl_o   = 1'b0;
                div_pulse_o = 1'b0;
            end
            ST_SWALLOW: begin
                mod_ctl_o   = 1'b1;
                div_pulse_o = b_one;
            end
            ST_MAIN: begin
                mod_ctl_o   = 1'b0;
                div_pulse_o = b_one;
            end
            default: begin
                mod_ctl_o   = 1'b0;
                div_pulse_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nmod_feedback_div_chk.sv
module nmod_feedback_div_chk #(
    parameter int A_W    = 6,
    parameter int B_W    = 13,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_ctl,
    input logic              div_pulse,
    input logic [MODE_W-1:0] psc_mode,
    input logic              cfg_invalid,
    input logic              run,
    input logic [A_W-1:0]    a_cnt,
    input logic [B_W-1:0]    b_cnt
);

    // R3: outside the terminal clock the period count steps down by one
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div_pulse) |=> (b_cnt == ($past(b_cnt) - B_W'(1))));

    // R2: a P+1 request always has swallow cycles left, never more than the period has left
    p_swallow_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ctl |-> ((a_cnt != '0) && ({{(B_W-A_W){1'b0}}, a_cnt} <= b_cnt)));

    // R7: the applied mode holds for the whole period
    p_mode_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div_pulse) |=> $stable(psc_mode));

    // R8: a boundary taken with invalid values leaves both outputs quiet
    p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && cfg_invalid) |=> (!mod_ctl && !div_pulse));

    // R3: no pulse while idle
    p_idle_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !div_pulse);

endmodule

bind nmod_feedback_div nmod_feedback_div_chk #(
    .A_W    (A_W),
    .B_W    (B_W),
    .MODE_W (MODE_W)
) u_chk_sva (
    .clk         (clk_psc),
    .rst_n       (rst_n),
    .mod_ctl     (mod_ctl_o),
    .div_pulse   (div_pulse_o),
    .psc_mode    (psc_mode_o),
    .cfg_invalid (cfg_invalid_o),
    .run         (run_q),
    .a_cnt       (a_cnt),
    .b_cnt       (b_cnt)
);

// File: tb/nmod_feedback_div_bench.sv
module nmod_feedback_div_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  a_in = 6'd3;
    logic [12:0] b_in = 13'd10;
    logic [1:0]  m_in = 2'd0;
    logic        mod_ctl;
    logic        div_pulse;
    logic [1:0]  mode_out;
    logic        cfg_inv;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int rf_acc = 0;
    int last_n = 0;
    bit done  = 0;

    // Behavioural reference: index within the period plus captured values
    bit m_active = 0;
    int m_k = 0, m_a = 0, m_b = 0, m_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmod_feedback_div u_nmod_feedback_div (
        .clk_psc       (clk),
        .rst_n         (rst_n),
        .swallow_i     (a_in),
        .main_i        (b_in),
        .psc_mode_i    (m_in),
        .mod_ctl_o     (mod_ctl),
        .div_pulse_o   (div_pulse),
        .psc_mode_o    (mode_out),
        .cfg_invalid_o (cfg_inv)
    );

    function automatic bit cfg_ok();
        return (int'(b_in) >= int'(a_in)) && (b_in != 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_a = 0; m_b = 0; m_mode = 0;
        end else if (!m_active || m_k == m_b - 1) begin
            if (cfg_ok()) begin
                m_active = 1; m_k = 0;
                m_a = int'(a_in); m_b = int'(b_in); m_mode = int'(m_in);
            end else begin
                m_active = 0;
            end
        end else begin
            m_k = m_k + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Per-clock comparison against the reference, away from the active edge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            begin
                bit e_mod, e_div, e_inv;
                e_mod = m_active && (m_k < m_a);
                e_div = m_active && (m_k == m_b - 1);
                e_inv = !cfg_ok();
                chk(mod_ctl == e_mod, "R2 mod_ctl (R7 R8 R9)", int'(mod_ctl), int'(e_mod));
                chk(div_pulse == e_div, "R3 div_pulse (R7 R8 R9)", int'(div_pulse), int'(e_div));
                chk(int'(mode_out) == m_mode, "R5 psc_mode (R7)", int'(mode_out), m_mode);
                chk(cfg_inv == e_inv, "R6 cfg_invalid", int'(cfg_inv), int'(e_inv));
                if (!m_active) begin
                    rf_acc = 0;
                end else begin
                    rf_acc += (8 << mode_out) + int'(mod_ctl);
                    if (e_div) begin
                        chk(rf_acc == m_b * (8 << m_mode) + m_a, "R4 RF cycles per period",
                            rf_acc, m_b * (8 << m_mode) + m_a);
                        last_n = rf_acc;
                        rf_acc = 0;
                    end
                end
            end
        end
    endtask

    task automatic set_cfg(input int a, input int b, input int m);
        a_in = 6'(a); b_in = 13'(b); m_in = 2'(m);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mod_ctl == 0, "R1 mod_ctl in reset", int'(mod_ctl), 0);
        chk(div_pulse == 0, "R1 div_pulse in reset", int'(div_pulse), 0);
        chk(mode_out == 0, "R1 psc_mode in reset", int'(mode_out), 0);
        rst_n = 1'b1;
        run(35);                       // A=3 B=10 P=8
        set_cfg(0, 5, 1);  run(20);    // no swallow cycles
        set_cfg(4, 4, 3);  run(16);    // R9: A equals B
        set_cfg(0, 1, 2);  run(8);     // R9: B of one, pulse every clock
        set_cfg(1, 1, 0);  run(8);
        set_cfg(5, 3, 1);  run(20);    // R8: B below A
        chk(cfg_inv == 1, "R6 flag for B<A", int'(cfg_inv), 1);
        chk(div_pulse == 0 && mod_ctl == 0, "R8 quiet while invalid",
            int'(div_pulse) + int'(mod_ctl), 0);
        set_cfg(0, 0, 1);  run(10);    // R8: B of zero
        chk(cfg_inv == 1, "R6 flag for B=0", int'(cfg_inv), 1);
        set_cfg(2, 6, 1);  run(3);     // R8: resume
        set_cfg(5, 9, 2);              // R7: edit mid-period
        run(1);
        chk(mode_out == 2'd1, "R7 mode unchanged mid-period", int'(mode_out), 1);
        run(30);
        set_cfg(63, 891, 2); run(2 * 891 + 12);
        chk(last_n == 28575, "R4 P=32 A=63 B=891", last_n, 28575);
        run(5);
        rst_n = 1'b0;                  // R1: asynchronous reset mid-run
        #1;
        chk(mod_ctl == 0 && div_pulse == 0 && mode_out == 0, "R1 after async reset",
            int'(mod_ctl) + int'(div_pulse) + int'(mode_out), 0);
        run(2);
        finish_run();
    end

endmodule